// File: doc/BRIEF.md
# Nonvolatile Array Program/Erase Sequencer

This block guards a small byte-wide nonvolatile array, modelled as a register array, behind a plain processor bus. It supports two operations: a whole-array erase and a program of bytes inside one 32-byte row. Either operation starts only after a fixed order of control writes, reads and array writes, and the high-voltage enable (HV) is honoured only after minimum waits. Each wait is measured in clock cycles as ceil(time × CLK_HZ). The waits are 10 µs before HV, 5 µs after HV before data, 4 ms of erase under HV, 100 µs of hold after erase, and 1 µs of recovery after HV is dropped.

The bus has a 9-bit byte address, write data, a write strobe, a read strobe and registered read data. Addresses 0x000–0x0FF select the array. 0x100 is the sequence control register: bit0 PGM, bit1 ERASE, bit2 MASS, bit3 HV. 0x101 is the protect register, which resets to 0xFF. 0x102 is status: bit0 busy, bit1 sticky error. Writing a 1 to status bit1 clears the error. A step that arrives out of order, or before its wait has elapsed, aborts the operation. An abort returns the block to idle, clears the control register, sets the error flag and leaves the array as it was. Accesses that are not sequence steps may be interleaved freely. These are array reads, status reads, extra protect reads and protect writes.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the protect register 0xFF, status 0x00 and every array byte 0xFF. Read data appears on bus_rdata one clock after the read strobe and holds until the next read.
- R2: The row program proceeds in this order: write 0x01 to control, read protect, write to any address in the target row (this latches the row), write 0x09 to control, then write data bytes. After control is written 0x00 and recovery ends, the programmed bytes read back with their new values.
- R3: A program data write changes a byte only if the byte currently holds 0xFF. Any other byte keeps its content.
- R4: During programming, a data write outside the latched 32-byte row (address bits [7:5] differ) leaves the array unchanged and sets the error flag. It does not end the operation.
- R5: If control is written 0x09 fewer than ceil(10 µs × CLK_HZ) cycles after the row-latch write, the operation aborts: status reads 0x02, control reads 0x00, and the array is unchanged.
- R6: A data write fewer than ceil(5 µs × CLK_HZ) cycles after HV was set aborts the program and leaves the array unchanged.
- R7: The mass erase proceeds in this order: write 0x06, read protect, write any array address, wait 10 µs, write 0x0E, wait 4 ms, write 0x08, wait 100 µs, write 0x00. This sets every byte to 0xFF, the two top bytes 0xFE and 0xFF included. If 0x08 is written before 4 ms have elapsed, the erase aborts and the array is unchanged.
- R8: Writing 0x06 to control while protect holds any value other than 0xFF is refused. The error flag is set and the block stays idle.
- R9: An out-of-order step aborts the operation with error. Writing HV from idle is an out-of-order step. The error stays set until status bit1 is written with 1.
- R10: Status busy reads 1 from the arming control write until recovery ends. While busy, array reads return 0xFF.
- R11: After control is written 0x00 from the HV stage, busy stays 1 for ceil(1 µs × CLK_HZ) cycles and then clears.
- R12: Array reads, status reads, protect writes and extra protect reads between steps do not disturb the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ARR_AW+1 | Byte address; the top bit selects register space |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |

## Verification
Read data appears on the clock edge after the read strobe, so every check samples on the falling edge that follows that edge. A step accepted at one edge is followed by its successor N edges later, and the control logic sees an elapsed count of N. The bench drives each timed step after a counted number of idle cycles, which places it exactly at the minimum wait or one cycle short of it. Recovery is observed with a status read on the cycle straight after HV is dropped, while it is still busy. A behavioural model is updated on every rising edge and predicts the read data due after each read strobe.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_P_ARM, S_P_LATCH, S_P_NVS, S_P_HV,
    S_E_ARM, S_E_LATCH, S_E_NVS, S_E_HV, S_E_NVH, S_REC
  } seq_state_e;

  // control register bit positions
  localparam int CB_PGM   = 0;
  localparam int CB_ERASE = 1;
  localparam int CB_MASS  = 2;
  localparam int CB_HV    = 3;

  localparam logic [3:0] CTL_NONE   = 4'b0000;
  localparam logic [3:0] CTL_PGM    = 4'b0001;
  localparam logic [3:0] CTL_PGM_HV = 4'b1001;
  localparam logic [3:0] CTL_EM     = 4'b0110;
  localparam logic [3:0] CTL_EM_HV  = 4'b1110;
  localparam logic [3:0] CTL_HV     = 4'b1000;

  // register offsets within register space
  localparam int REG_CTL  = 0;
  localparam int REG_PROT = 1;
  localparam int REG_STAT = 2;

  // cycles = ceil(hz * num / den)
  function automatic longint unsigned cyc_ceil(longint unsigned hz,
                                               longint unsigned num,
                                               longint unsigned den);
    return (hz * num + den - 1) / den;
  endfunction

endpackage

// File: rtl/fsq_rst_sync.sv
module fsq_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/fsq_timer.sv
module fsq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart)             cnt_d = CNT_W'(1);
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/fsq_array.sv
module fsq_array #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          prog_en,
  input  logic          erase_en,
  output logic [7:0]    rd_byte
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    logic [7:0] cell_q, cell_d;
    logic       hit, cell_en;

    assign hit     = prog_en && (addr == AW'(gi)) && (cell_q == 8'hFF);
    assign cell_en = erase_en || hit;

    always_comb begin
      if (erase_en) cell_d = 8'hFF;
      else          cell_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= 8'hFF;
      else if (cell_en) cell_q <= cell_d;
    end

    assign mem[gi] = cell_q;
  end

  assign rd_byte = mem[addr];

  // R3
  keep_nonblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !erase_en && rd_byte != 8'hFF) |=> (mem[$past(addr)] == $past(rd_byte)));

  // R7
  erase_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF && mem[DEPTH-2] == 8'hFF));
endmodule

// File: rtl/fsq_sequencer.sv
module fsq_sequencer
  import flash_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 8_000_000,
  parameter int CNT_W = 16,
  parameter int RW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [3:0]       ctl_val,
  input  logic             prot_rd,
  input  logic             prot_ok,
  input  logic             arr_wr,
  input  logic [RW-1:0]    arr_row,
  input  logic [CNT_W-1:0] cnt,
  output logic [3:0]       ctl_q,
  output logic             busy,
  output logic             cnt_restart,
  output logic             err_set,
  output logic             prog_en,
  output logic             erase_en
);
  localparam logic [CNT_W-1:0] T_NVS  = CNT_W'(cyc_ceil(CLK_HZ, 10, 1_000_000));
  localparam logic [CNT_W-1:0] T_PGS  = CNT_W'(cyc_ceil(CLK_HZ, 5, 1_000_000));
  localparam logic [CNT_W-1:0] T_ME   = CNT_W'(cyc_ceil(CLK_HZ, 4, 1_000));
  localparam logic [CNT_W-1:0] T_NVHL = CNT_W'(cyc_ceil(CLK_HZ, 100, 1_000_000));
  localparam logic [CNT_W-1:0] T_RCV  = CNT_W'(cyc_ceil(CLK_HZ, 1, 1_000_000));

  seq_state_e    st_q, st_d;
  logic [3:0]    ctl_d;
  logic [RW-1:0] row_q, row_d;
  logic          abort;

  always_comb begin
    st_d        = st_q;
    ctl_d       = ctl_q;
    row_d       = row_q;
    cnt_restart = 1'b0;
    err_set     = 1'b0;
    prog_en     = 1'b0;
    erase_en    = 1'b0;
    abort       = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (ctl_wr) begin
          if (ctl_val == CTL_PGM) begin
            st_d  = S_P_ARM;
            ctl_d = CTL_PGM;
          end else if (ctl_val == CTL_EM) begin
            if (prot_ok) begin
              st_d  = S_E_ARM;
              ctl_d = CTL_EM;
            end else begin
              err_set = 1'b1;
            end
          end else if (ctl_val != CTL_NONE) begin
            err_set = 1'b1;
          end
        end
      end
      S_P_ARM, S_E_ARM: begin
        if (ctl_wr || arr_wr) abort = 1'b1;
        else if (prot_rd)     st_d = (st_q == S_P_ARM) ? S_P_LATCH : S_E_LATCH;
      end
      S_P_LATCH, S_E_LATCH: begin
        if (ctl_wr) begin
          abort = 1'b1;
        end else if (arr_wr) begin
          row_d       = arr_row;
          cnt_restart = 1'b1;
          st_d        = (st_q == S_P_LATCH) ? S_P_NVS : S_E_NVS;
        end
      end
      S_P_NVS: begin
        if (arr_wr) begin
          abort = 1'b1;
        end else if (ctl_wr) begin
          if (ctl_val == CTL_PGM_HV && cnt >= T_NVS) begin
            st_d        = S_P_HV;
            ctl_d       = CTL_PGM_HV;
            cnt_restart = 1'b1;
          end else begin
            abort = 1'b1;
          end
        end
      end
      S_P_HV: begin
        if (ctl_wr) begin
          if (ctl_val == CTL_NONE) begin
            st_d        = S_REC;
            ctl_d       = CTL_NONE;
            cnt_restart = 1'b1;
          end else begin
            abort = 1'b1;
          end
        end else if (arr_wr) begin
          if (cnt < T_PGS)           abort   = 1'b1;
          else if (arr_row == row_q) prog_en = 1'b1;
          else                       err_set = 1'b1;
        end
      end
      S_E_NVS: begin
        if (arr_wr) begin
          abort = 1'b1;
        end else if (ctl_wr) begin
          if (ctl_val == CTL_EM_HV && cnt >= T_NVS) begin
            st_d        = S_E_HV;
            ctl_d       = CTL_EM_HV;
            cnt_restart = 1'b1;
          end else begin
            abort = 1'b1;
          end
        end
      end
      S_E_HV: begin
        if (arr_wr) begin
          abort = 1'b1;
        end else if (ctl_wr) begin
          if (ctl_val == CTL_HV && cnt >= T_ME) begin
            st_d        = S_E_NVH;
            ctl_d       = CTL_HV;
            cnt_restart = 1'b1;
          end else begin
            abort = 1'b1;
          end
        end
      end
      S_E_NVH: begin
        if (arr_wr) begin
          abort = 1'b1;
        end else if (ctl_wr) begin
          if (ctl_val == CTL_NONE && cnt >= T_NVHL) begin
            erase_en    = 1'b1;
            st_d        = S_REC;
            ctl_d       = CTL_NONE;
            cnt_restart = 1'b1;
          end else begin
            abort = 1'b1;
          end
        end
      end
      S_REC: begin
        if (ctl_wr || arr_wr) abort = 1'b1;
        else if (cnt >= T_RCV) st_d = S_IDLE;
      end
      default: abort = 1'b1;
    endcase
    if (abort) begin
      st_d        = S_IDLE;
      ctl_d       = CTL_NONE;
      err_set     = 1'b1;
      prog_en     = 1'b0;
      erase_en    = 1'b0;
      cnt_restart = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      ctl_q <= CTL_NONE;
      row_q <= '0;
    end else begin
      st_q  <= st_d;
      ctl_q <= ctl_d;
      row_q <= row_d;
    end
  end

  assign busy = (st_q != S_IDLE);

  // R5
  early_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_P_NVS && ctl_wr && cnt < T_NVS) |=> (st_q == S_IDLE && ctl_q == CTL_NONE));

  // R6
  early_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_P_HV && arr_wr && !ctl_wr && cnt < T_PGS) |=> (st_q == S_IDLE));

  // R8
  protect_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && ctl_wr && ctl_val == CTL_EM && !prot_ok) |=> (st_q == S_IDLE));

  // R9
  hv_only_staged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CB_HV] |-> (st_q == S_P_HV || st_q == S_E_HV || st_q == S_E_NVH));

  // R7
  erase_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |-> (st_q == S_E_NVH && cnt >= T_NVHL));
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 8_000_000,
  parameter int ARR_AW = 8,
  parameter int ROW_AW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ARR_AW:0] bus_addr,
  input  logic [7:0]      bus_wdata,
  input  logic            bus_wr,
  input  logic            bus_rd,
  output logic [7:0]      bus_rdata
);
  localparam int RW = ARR_AW - ROW_AW;
  localparam longint unsigned T_ME_L = cyc_ceil(CLK_HZ, 4, 1_000);
  localparam int CNT_W = $clog2(T_ME_L + 2) + 1;

  logic              rst_n_s;
  logic              is_reg, ctl_hit, prot_hit, stat_hit;
  logic              arr_wr, arr_rd, ctl_wr, prot_rd, prot_wr, err_clr;
  logic [ARR_AW-1:0] off;
  logic [7:0]        prot_q, prot_d, rd_q, rd_d, arr_byte;
  logic              err_q, err_d;
  logic [CNT_W-1:0]  cnt;
  logic [3:0]        ctl_q;
  logic              busy, cnt_restart, err_set, prog_en, erase_en;

  fsq_rst_sync u_rst (.clk(clk), .rst_n_a(rst_n), .rst_n_s(rst_n_s));

  // bus decode
  assign is_reg   = bus_addr[ARR_AW];
  assign off      = bus_addr[ARR_AW-1:0];
  assign ctl_hit  = is_reg && (off == ARR_AW'(REG_CTL));
  assign prot_hit = is_reg && (off == ARR_AW'(REG_PROT));
  assign stat_hit = is_reg && (off == ARR_AW'(REG_STAT));
  assign arr_wr   = bus_wr && !is_reg;
  assign arr_rd   = bus_rd && !is_reg;
  assign ctl_wr   = bus_wr && ctl_hit;
  assign prot_wr  = bus_wr && prot_hit;
  assign prot_rd  = bus_rd && prot_hit;
  assign err_clr  = bus_wr && stat_hit && bus_wdata[1];

  fsq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .restart(cnt_restart), .cnt(cnt)
  );

  fsq_sequencer #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W), .RW(RW)) u_seq (
    .clk(clk), .rst_n(rst_n_s),
    .ctl_wr(ctl_wr), .ctl_val(bus_wdata[3:0]),
    .prot_rd(prot_rd), .prot_ok(prot_q == 8'hFF),
    .arr_wr(arr_wr), .arr_row(off[ARR_AW-1:ROW_AW]),
    .cnt(cnt),
    .ctl_q(ctl_q), .busy(busy), .cnt_restart(cnt_restart),
    .err_set(err_set), .prog_en(prog_en), .erase_en(erase_en)
  );

  fsq_array #(.AW(ARR_AW)) u_arr (
    .clk(clk), .rst_n(rst_n_s), .addr(off), .wdata(bus_wdata),
    .prog_en(prog_en), .erase_en(erase_en), .rd_byte(arr_byte)
  );

  // register next state
  always_comb begin
    prot_d = prot_wr ? bus_wdata : prot_q;
    err_d  = err_set || (err_q && !err_clr);
    rd_d   = rd_q;
    if (bus_rd) begin
      if (is_reg) begin
        if (ctl_hit)       rd_d = {4'h0, ctl_q};
        else if (prot_hit) rd_d = prot_q;
        else if (stat_hit) rd_d = {6'b0, err_q, busy};
        else               rd_d = 8'h00;
      end else begin
        rd_d = busy ? 8'hFF : arr_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      prot_q <= 8'hFF;
      err_q  <= 1'b0;
      rd_q   <= 8'h00;
    end else begin
      prot_q <= prot_d;
      err_q  <= err_d;
      rd_q   <= rd_d;
    end
  end

  assign bus_rdata = rd_q;

  // R10
  busy_read_blank_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (arr_rd && busy) |=> (bus_rdata == 8'hFF));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (err_q && !err_clr) |=> err_q);
endmodule

// File: tb/sim_flash_seq_ctrl.sv
`timescale 1ns/1ps
module sim_flash_seq_ctrl;
  localparam longint unsigned HZ = 1_000_000;
  // waits in cycles for HZ: 10us, 5us, 4ms, 100us, 1us
  localparam int W_NVS = 10, W_PGS = 5, W_ME = 4000, W_NVHL = 100, W_RCV = 1;
  localparam logic [8:0] A_CTL = 9'h100, A_PROT = 9'h101, A_STAT = 9'h102;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] b_addr = '0;
  logic [7:0] b_wdata = '0;
  logic       b_wr = 1'b0, b_rd = 1'b0;
  logic [7:0] rdata;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flash_seq_ctrl #(.CLK_HZ(HZ), .ARR_AW(8), .ROW_AW(5)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wdata(b_wdata),
    .bus_wr(b_wr), .bus_rd(b_rd), .bus_rdata(rdata)
  );

  // ---------------- behavioural reference model ----------------
  int         ph, el, m_ctl, m_row;
  logic [7:0] m_prot, exp_rd;
  logic [7:0] m_mem [256];
  bit         m_err, rd_seen;
  string      cur_req = "R1";

  always @(posedge clk) begin
    bit ab, sf, cw, aw, isr, clr;
    int off, cv;
    if (!rst_n) begin
      ph = 0; el = 0; m_err = 0; m_ctl = 0; m_row = 0;
      m_prot = 8'hFF; exp_rd = 8'h00; rd_seen = 0;
      for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
    end else begin
      isr = b_addr[8]; off = int'(b_addr[7:0]); cv = int'(b_wdata[3:0]);
      cw  = b_wr && isr && off == 0;
      aw  = b_wr && !isr;
      clr = b_wr && isr && off == 2 && b_wdata[1];
      ab = 0; sf = 0;
      rd_seen = b_rd;
      if (b_rd) begin
        if (isr) exp_rd = (off == 0) ? 8'(m_ctl) : (off == 1) ? m_prot :
                          (off == 2) ? {6'b0, m_err, ph != 0} : 8'h00;
        else     exp_rd = (ph != 0) ? 8'hFF : m_mem[off];
      end
      el = el + 1;
      case (ph)
        0: if (cw) begin
             if (cv == 1) begin ph = 1; m_ctl = 1; end
             else if (cv == 6) begin
               if (m_prot == 8'hFF) begin ph = 5; m_ctl = 6; end else sf = 1;
             end else if (cv != 0) sf = 1;
           end
        1, 5: if (cw || aw) ab = 1; else if (b_rd && isr && off == 1) ph = ph + 1;
        2, 6: if (cw) ab = 1; else if (aw) begin m_row = off / 32; el = 0; ph = ph + 1; end
        3: if (aw) ab = 1;
           else if (cw) begin
             if (cv == 9 && el >= W_NVS) begin ph = 4; m_ctl = 9; el = 0; end else ab = 1;
           end
        4: if (cw) begin
             if (cv == 0) begin ph = 10; m_ctl = 0; el = 0; end else ab = 1;
           end else if (aw) begin
             if (el < W_PGS) ab = 1;
             else if (off / 32 == m_row) begin
               if (m_mem[off] == 8'hFF) m_mem[off] = b_wdata;
             end else sf = 1;
           end
        7: if (aw) ab = 1;
           else if (cw) begin
             if (cv == 14 && el >= W_NVS) begin ph = 8; m_ctl = 14; el = 0; end else ab = 1;
           end
        8: if (aw) ab = 1;
           else if (cw) begin
             if (cv == 8 && el >= W_ME) begin ph = 9; m_ctl = 8; el = 0; end else ab = 1;
           end
        9: if (aw) ab = 1;
           else if (cw) begin
             if (cv == 0 && el >= W_NVHL) begin
               for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
               ph = 10; m_ctl = 0; el = 0;
             end else ab = 1;
           end
        10: if (cw || aw) ab = 1; else if (el >= W_RCV) ph = 0;
        default: ab = 1;
      endcase
      if (ab) begin ph = 0; m_ctl = 0; sf = 1; end
      m_err = sf || (m_err && !clr);
      if (b_wr && isr && off == 1) m_prot = b_wdata;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // per-clock comparison of read data against the model
  always @(negedge clk) begin
    if (rst_n && rd_seen) check({cur_req, " model"}, rdata, exp_rd);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk); b_addr = a; b_wdata = d; b_wr = 1'b1;
    @(negedge clk); b_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [8:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); b_addr = a; b_rd = 1'b1;
    @(negedge clk); b_rd = 1'b0;
    check(tag, rdata, exp);
  endtask

  // write, then read status on the very next cycle
  task automatic wr_then_stat(input logic [8:0] a, input logic [7:0] d,
                              input logic [7:0] exp, input string tag);
    @(negedge clk); b_addr = a; b_wdata = d; b_wr = 1'b1;
    @(negedge clk); b_wr = 1'b0; b_addr = A_STAT; b_rd = 1'b1;
    @(negedge clk); b_rd = 1'b0;
    check(tag, rdata, exp);
  endtask

  // arm a row program; a gap of c idle cycles gives an elapsed count of c+2
  task automatic prog_open(input logic [8:0] row_a);
    wr(A_CTL, 8'h01);
    rd_chk(A_PROT, 8'hFF, "R2");
    wr(row_a, 8'h00);
    idle(W_NVS - 2);
    wr(A_CTL, 8'h09);
    idle(W_PGS - 2);
  endtask

  task automatic prog_close();
    wr(A_CTL, 8'h00);
    idle(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    cur_req = "R1";
    rd_chk(A_CTL, 8'h00, "R1");
    rd_chk(A_PROT, 8'hFF, "R1");
    rd_chk(A_STAT, 8'h00, "R1");
    rd_chk(9'h041, 8'hFF, "R1");

    // R2 / R12 / R4 / R10 / R11 row program with interleaved accesses
    cur_req = "R2";
    wr(A_CTL, 8'h01);
    rd_chk(A_STAT, 8'h01, "R10");
    rd_chk(A_PROT, 8'hFF, "R2");
    wr(9'h040, 8'h00);
    rd_chk(9'h041, 8'hFF, "R10");
    wr(A_PROT, 8'hFF);
    idle(W_NVS - 6);
    wr(A_CTL, 8'h09);
    rd_chk(A_CTL, 8'h09, "R12");
    idle(W_PGS - 4);
    wr(9'h041, 8'h5A);
    wr(9'h045, 8'h33);
    wr(9'h061, 8'h77);
    rd_chk(A_STAT, 8'h03, "R4");
    cur_req = "R11";
    wr_then_stat(A_CTL, 8'h00, 8'h03, "R11");
    rd_chk(A_STAT, 8'h02, "R11");
    rd_chk(9'h041, 8'h5A, "R2");
    rd_chk(9'h045, 8'h33, "R2");
    rd_chk(9'h061, 8'hFF, "R4");
    wr(A_STAT, 8'h02);
    rd_chk(A_STAT, 8'h00, "R9");

    // R3 only erased bytes change; load the two top bytes too
    cur_req = "R3";
    prog_open(9'h050);
    wr(9'h041, 8'h00);
    wr(9'h042, 8'h11);
    prog_close();
    rd_chk(9'h041, 8'h5A, "R3");
    rd_chk(9'h042, 8'h11, "R3");
    prog_open(9'h0E3);
    wr(9'h0FE, 8'h12);
    wr(9'h0FF, 8'h34);
    prog_close();
    rd_chk(9'h0FE, 8'h12, "R3");

    // R5 HV one cycle early
    cur_req = "R5";
    wr(A_CTL, 8'h01);
    rd_chk(A_PROT, 8'hFF, "R5");
    wr(9'h080, 8'h00);
    idle(W_NVS - 3);
    wr(A_CTL, 8'h09);
    rd_chk(A_STAT, 8'h02, "R5");
    rd_chk(A_CTL, 8'h00, "R5");
    wr(9'h081, 8'hAB);
    rd_chk(9'h081, 8'hFF, "R5");
    wr(A_STAT, 8'h02);

    // R6 data write one cycle early
    cur_req = "R6";
    wr(A_CTL, 8'h01);
    rd_chk(A_PROT, 8'hFF, "R6");
    wr(9'h080, 8'h00);
    idle(W_NVS - 2);
    wr(A_CTL, 8'h09);
    idle(W_PGS - 3);
    wr(9'h081, 8'hCD);
    rd_chk(A_STAT, 8'h02, "R6");
    rd_chk(9'h081, 8'hFF, "R6");
    wr(A_STAT, 8'h02);

    // R9 out-of-order steps
    cur_req = "R9";
    wr(A_CTL, 8'h01);
    wr(9'h020, 8'h00);
    rd_chk(A_STAT, 8'h02, "R9");
    rd_chk(A_CTL, 8'h00, "R9");
    wr(A_STAT, 8'h00);
    rd_chk(A_STAT, 8'h02, "R9");
    wr(A_STAT, 8'h02);
    wr(A_CTL, 8'h08);
    rd_chk(A_STAT, 8'h02, "R9");
    wr(A_STAT, 8'h02);

    // R8 protect veto
    cur_req = "R8";
    wr(A_PROT, 8'h7F);
    wr(A_CTL, 8'h06);
    rd_chk(A_STAT, 8'h02, "R8");
    rd_chk(A_CTL, 8'h00, "R8");
    wr(A_PROT, 8'hFF);
    wr(A_STAT, 8'h02);

    // R7 erase cut short one cycle before 4 ms
    cur_req = "R7";
    wr(A_CTL, 8'h06);
    rd_chk(A_PROT, 8'hFF, "R7");
    wr(9'h010, 8'h00);
    idle(W_NVS - 2);
    wr(A_CTL, 8'h0E);
    idle(W_ME - 3);
    wr(A_CTL, 8'h08);
    rd_chk(A_STAT, 8'h02, "R7");
    rd_chk(9'h041, 8'h5A, "R7");
    wr(A_STAT, 8'h02);

    // R7 complete erase at exact minimum waits
    wr(A_CTL, 8'h06);
    rd_chk(A_STAT, 8'h01, "R10");
    rd_chk(A_PROT, 8'hFF, "R7");
    wr(9'h010, 8'h00);
    idle(W_NVS - 2);
    wr(A_CTL, 8'h0E);
    idle(W_ME - 2);
    wr(A_CTL, 8'h08);
    idle(W_NVHL - 2);
    wr_then_stat(A_CTL, 8'h00, 8'h01, "R11");
    rd_chk(A_STAT, 8'h00, "R7");
    rd_chk(9'h041, 8'hFF, "R7");
    rd_chk(9'h042, 8'hFF, "R7");
    rd_chk(9'h0FE, 8'hFF, "R7");
    rd_chk(9'h0FF, 8'hFF, "R7");

    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule